// File: doc/BRIEF.md
# SCSI Bus Arbitration Sequencer

This block carries a host-programmed SCSI controller through the arbitration phase. Software loads the device's one-hot ID into an output data register and raises an arbitrate control bit. The block then watches the sampled BSY and SEL lines until the bus has stayed quiet for a programmable settle period. It then asserts BSY, drives its ID onto the data lines and waits a programmable arbitration delay before it samples the data lines to resolve priority.

A higher-numbered data bit beats the device, and so does a SEL raised by another device while the bus is driven. When either happens the block releases everything it drives and raises a lost flag. If neither happens, the block has won: it keeps BSY and its ID on the bus until software clears the arbitrate bit, which is the point where the selection logic takes over. The in-progress flag comes on when the bus is first driven. Clearing the arbitrate bit in any state ends the sequence and clears both flags.

All bus signals at the ports are active-high. Conversion to and from the bus's inverted levels happens outside the block.

Top module: `scsi_arb_seq`

## Requirements
- R1: After reset, bus_bsy_o, bus_db_oe, bus_db_o, stat_aip and stat_la are all 0.
- R2: When arb_en rises on an idle bus, bus_bsy_o first reads 1 on the (settle_cycles+1)th rising edge after the edge that samples arb_en high. Nothing is driven before that edge.
- R3: While the block waits for a free bus, any cycle with bus_bsy_i or bus_sel_i high restarts the quiet count. Once the bus goes quiet again, another settle_cycles+1 quiet edges are needed before BSY is driven.
- R4: While the bus is driven, bus_bsy_o=1, bus_db_oe=1, bus_db_o equals out_data, and stat_aip=1.
- R5: The data lines are sampled on the (arb_delay+1)th rising edge after driving starts, and not before. If no bit of bus_db_i above the device's own ID bit is 1, the block wins.
- R6: If a bit of bus_db_i above the own ID bit is 1 at the sample edge, the block releases bus_bsy_o, bus_db_oe and bus_db_o and sets stat_la=1, while stat_aip stays 1.
- R7: If bus_sel_i is 1 in any cycle while the bus is driven, the block loses on the next rising edge, with the outputs of R6.
- R8: Bits of bus_db_i below the own ID bit have no effect on the result. An ID in bit 7 wins against any other IDs.
- R9: After a win, BSY and the ID stay driven and stat_la stays 0 for as long as arb_en stays 1.
- R10: When arb_en is 0 at a rising edge, every output is 0 after that edge, whatever the state was. This includes waiting, driving, won and lost.
- R11: stat_la and stat_aip stay set for as long as arb_en stays 1, whatever the bus does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_en | input | 1 | Arbitrate control bit from the register port |
| out_data | input | ID_W | Output data register: the device's one-hot ID |
| settle_cycles | input | CNT_W | Quiet cycles beyond the first needed for bus-free |
| arb_delay | input | CNT_W | Cycles beyond the first between driving and sampling |
| bus_bsy_i | input | 1 | Sampled BSY, active-high |
| bus_sel_i | input | 1 | Sampled SEL, active-high |
| bus_db_i | input | ID_W | Sampled data lines, active-high |
| bus_bsy_o | output | 1 | BSY drive request |
| bus_db_o | output | ID_W | Data line drive value |
| bus_db_oe | output | 1 | Data line drive enable |
| stat_aip | output | 1 | Arbitration-in-progress status bit |
| stat_la | output | 1 | Lost-arbitration status bit |

## Verification
The bound checker checks four things on every cycle. A clear arbitrate bit releases every output on the next edge. BSY never rises unless the bus was quiet in the cycle before. A driven bus always shows the in-progress flag and never the lost flag. The lost flag only appears out of a driving state and stays set until abort. The exact edge counts for the settle period, the restart of the quiet count and the arbitration delay can only be shown by the bench's scenarios. The same holds for the priority outcome for IDs above and below the device's own, the loss caused by SEL, and holding the bus after a win.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_DRIVE = 3'd2,
    ST_WON   = 3'd3,
    ST_LOST  = 3'd4
  } arb_state_e;
endpackage

// File: rtl/arb_free_det.sv
module arb_free_det #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             quiet,
  input  logic [CNT_W-1:0] settle,
  output logic             bus_free
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!run || !quiet) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign bus_free = run && quiet && (cnt_q >= settle);
endmodule

// File: rtl/arb_prio.sv
module arb_prio #(
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0] own_id,
  input  logic [ID_W-1:0] seen,
  output logic            higher_hit
);
  logic [ID_W-1:0] above;

  assign above[0] = 1'b0;
  for (genvar i = 1; i < ID_W; i++) begin : g_above
    assign above[i] = above[i-1] | own_id[i-1];
  end

  assign higher_hit = |(seen & above & ~own_id);
endmodule

// File: rtl/scsi_arb_seq.sv
module scsi_arb_seq
  import arb_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arb_en,
  input  logic [ID_W-1:0]  out_data,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic [CNT_W-1:0] arb_delay,
  input  logic             bus_bsy_i,
  input  logic             bus_sel_i,
  input  logic [ID_W-1:0]  bus_db_i,
  output logic             bus_bsy_o,
  output logic [ID_W-1:0]  bus_db_o,
  output logic             bus_db_oe,
  output logic             stat_aip,
  output logic             stat_la
);
  localparam logic [CNT_W-1:0] DLY_MAX = {CNT_W{1'b1}};

  arb_state_e       state_q, state_d;
  logic [CNT_W-1:0] dly_q, dly_d;
  logic             dly_en;
  logic             bus_free;
  logic             higher_hit;
  logic             driving;

  arb_free_det #(.CNT_W(CNT_W)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state_q == ST_WAIT),
    .quiet    (!bus_bsy_i && !bus_sel_i),
    .settle   (settle_cycles),
    .bus_free (bus_free)
  );

  arb_prio #(.ID_W(ID_W)) u_prio (
    .own_id     (out_data),
    .seen       (bus_db_i),
    .higher_hit (higher_hit)
  );

  always_comb begin
    state_d = state_q;
    if (!arb_en) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_WAIT;
        ST_WAIT:  if (bus_free) state_d = ST_DRIVE;
        ST_DRIVE: begin
          if (bus_sel_i) begin
            state_d = ST_LOST;
          end else if (dly_q >= arb_delay) begin
            state_d = higher_hit ? ST_LOST : ST_WON;
          end
        end
        ST_WON:   state_d = ST_WON;
        ST_LOST:  state_d = ST_LOST;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dly_en = 1'b1;
    dly_d  = dly_q;
    if (state_q != ST_DRIVE) begin
      dly_d = '0;
    end else if (dly_q != DLY_MAX) begin
      dly_d = dly_q + 1'b1;
    end else begin
      dly_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
    end else if (dly_en) begin
      dly_q <= dly_d;
    end
  end

  assign driving   = (state_q == ST_DRIVE) || (state_q == ST_WON);
  assign bus_bsy_o = driving;
  assign bus_db_oe = driving;
  assign bus_db_o  = driving ? out_data : '0;
  assign stat_aip  = driving || (state_q == ST_LOST);
  assign stat_la   = (state_q == ST_LOST);
endmodule

module scsi_arb_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic arb_en,
  input logic bus_bsy_i,
  input logic bus_sel_i,
  input logic bus_bsy_o,
  input logic stat_aip,
  input logic stat_la
);
  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |=> (!bus_bsy_o && !stat_aip && !stat_la));

  // R2
  free_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_bsy_o) |-> $past(!bus_bsy_i && !bus_sel_i));

  // R4
  drive_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_bsy_o |-> (stat_aip && !stat_la));

  // R11
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_la && arb_en) |=> (stat_la && stat_aip));

  // R6
  lost_from_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_la) |-> $past(bus_bsy_o));
endmodule

bind scsi_arb_seq scsi_arb_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arb_en    (arb_en),
  .bus_bsy_i (bus_bsy_i),
  .bus_sel_i (bus_sel_i),
  .bus_bsy_o (bus_bsy_o),
  .stat_aip  (stat_aip),
  .stat_la   (stat_la)
);

// File: tb/scsi_arb_seq_bench.sv
module scsi_arb_seq_bench;
  logic       clk;
  logic       rst_n;
  logic       arb_en;
  logic [7:0] out_data;
  logic [7:0] settle_cycles;
  logic [7:0] arb_delay;
  logic       bus_bsy_i;
  logic       bus_sel_i;
  logic [7:0] bus_db_i;
  logic       bus_bsy_o;
  logic [7:0] bus_db_o;
  logic       bus_db_oe;
  logic       stat_aip;
  logic       stat_la;

  int checks = 0;
  int errors = 0;

  scsi_arb_seq u_scsi_arb_seq (
    .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .out_data(out_data),
    .settle_cycles(settle_cycles), .arb_delay(arb_delay),
    .bus_bsy_i(bus_bsy_i), .bus_sel_i(bus_sel_i), .bus_db_i(bus_db_i),
    .bus_bsy_o(bus_bsy_o), .bus_db_o(bus_db_o), .bus_db_oe(bus_db_oe),
    .stat_aip(stat_aip), .stat_la(stat_la)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] outs();
    return {19'd0, bus_bsy_o, bus_db_oe, stat_aip, stat_la, bus_db_o};
  endfunction

  task automatic gap();
    arb_en = 1'b0; bus_bsy_i = 1'b0; bus_sel_i = 1'b0; bus_db_i = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic launch(input logic [7:0] own, output int n);
    out_data = own;
    arb_en   = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bus_bsy_o && n < 500);
  endtask

  task automatic t_reset();
    chk("R1 outputs after reset", outs(), 32'd0);
  endtask

  task automatic t_win_lower();
    int n;
    settle_cycles = 8'd3; arb_delay = 8'd2;
    bus_db_i = 8'h10 | 8'h08 | 8'h01;
    launch(8'h10, n);
    chk("R2 edges to BSY", n, 32'd5);
    chk("R4 drive outputs", outs(), {19'd0, 4'b1110, 8'h10});
    repeat (2) @(negedge clk);
    chk("R5 no sample before delay", {stat_la, bus_bsy_o}, 2'b01);
    @(negedge clk);
    chk("R8 lower IDs ignored, win", {stat_la, bus_bsy_o, stat_aip}, 3'b011);
    gap();
  endtask

  task automatic t_lose_higher();
    int n;
    settle_cycles = 8'd3; arb_delay = 8'd2;
    bus_db_i = 8'h10 | 8'h40;
    launch(8'h10, n);
    chk("R2 edges to BSY, lose case", n, 32'd5);
    repeat (2) @(negedge clk);
    chk("R5 still driving before sample", outs(), {19'd0, 4'b1110, 8'h10});
    @(negedge clk);
    chk("R6 higher ID loses", outs(), {19'd0, 4'b0011, 8'h00});
    bus_db_i = '0; bus_bsy_i = 1'b1; bus_sel_i = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 lost flag sticky", {stat_aip, stat_la, bus_bsy_o}, 3'b110);
    arb_en = 1'b0;
    @(negedge clk);
    chk("R10 abort from lost", outs(), 32'd0);
    gap();
  endtask

  task automatic t_edge_ids();
    int n;
    settle_cycles = 8'd1; arb_delay = 8'd1;
    bus_db_i = 8'hFF;
    launch(8'h80, n);
    chk("R2 edges to BSY, settle 1", n, 32'd3);
    repeat (2) @(negedge clk);
    chk("R8 top ID beats all", {stat_la, bus_bsy_o, bus_db_o}, {2'b01, 8'h80});
    gap();
    bus_db_i = 8'h03;
    launch(8'h01, n);
    repeat (2) @(negedge clk);
    chk("R6 bottom ID loses to next", {stat_la, bus_bsy_o, bus_db_oe}, 3'b100);
    gap();
  endtask

  task automatic t_sel_loss();
    int n;
    settle_cycles = 8'd2; arb_delay = 8'd6;
    bus_db_i = 8'h04;
    launch(8'h04, n);
    @(negedge clk);
    bus_sel_i = 1'b1;
    @(negedge clk);
    chk("R7 SEL during drive loses", outs(), {19'd0, 4'b0011, 8'h00});
    gap();
  endtask

  task automatic t_settle_restart();
    int n;
    settle_cycles = 8'd4; arb_delay = 8'd2;
    out_data = 8'h02; arb_en = 1'b1;
    repeat (3) @(negedge clk);
    bus_bsy_i = 1'b1;
    @(negedge clk);
    bus_bsy_i = 1'b0;
    chk("R3 nothing driven while busy", outs(), 32'd0);
    repeat (4) @(negedge clk);
    chk("R3 count restarted, not yet driving", bus_bsy_o, 1'b0);
    @(negedge clk);
    chk("R3 drive after full quiet period", bus_bsy_o, 1'b1);
    gap();
    bus_sel_i = 1'b1; out_data = 8'h02; arb_en = 1'b1;
    repeat (12) @(negedge clk);
    chk("R3 held SEL keeps bus not free", outs(), 32'd0);
    gap();
  endtask

  task automatic t_hold_and_abort();
    int n;
    settle_cycles = 8'd0; arb_delay = 8'd0;
    bus_db_i = 8'h20;
    launch(8'h20, n);
    chk("R2 edges to BSY, settle 0", n, 32'd2);
    @(negedge clk);
    bus_db_i = 8'hC0;
    repeat (20) @(negedge clk);
    chk("R9 won holds bus", outs(), {19'd0, 4'b1110, 8'h20});
    arb_en = 1'b0;
    @(negedge clk);
    chk("R10 abort from won", outs(), 32'd0);
    gap();
    settle_cycles = 8'd3; arb_delay = 8'd5;
    launch(8'h20, n);
    arb_en = 1'b0;
    @(negedge clk);
    chk("R10 abort while driving", outs(), 32'd0);
    gap();
    out_data = 8'h20; arb_en = 1'b1;
    repeat (2) @(negedge clk);
    arb_en = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 abort while waiting", outs(), 32'd0);
    gap();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; arb_en = 1'b0; out_data = '0;
    settle_cycles = 8'd3; arb_delay = 8'd2;
    bus_bsy_i = 1'b0; bus_sel_i = 1'b0; bus_db_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_win_lower();
    t_lose_higher();
    t_edge_ids();
    t_sel_loss();
    t_settle_restart();
    t_hold_and_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule